// File: doc/BRIEF.md
# USB Endpoint Control Register Bank

This block holds the per-endpoint control state of a USB device controller. A CPU reaches it through a plain register port. One address holds the control byte of the endpoint picked by an endpoint index. The other address holds a vector of FIFO reset bits, one bit per endpoint. The block drives the STALL handshake requests, the current data toggle of every endpoint, the endpoint enables, the data-flow-engine routing and run controls, and the FIFO reset lines.

The USB protocol engine feeds three kinds of event into the bank: a received SETUP (tagged with its endpoint), an acknowledged data packet (also tagged), and a USB bus reset. Some control bits can only be set by software. Hardware clears them, either on an event or one cycle after they were set. Writes take effect at the clock edge. Reads are combinational from the current state.

Top module: `epCtlBank`

## Requirements
- R1: After reset, every endpoint's control byte reads 0x00 except endpoint 0, which reads 0x01 (enabled). The FIFO reset register reads 0x00, and the toggle, stall and FIFO reset outputs are all 0.
- R2: In the control byte (regSel=0), bits 7:6 always read 0 and writes to them are dropped. In the FIFO reset register (regSel=1), bit 7 always reads 0.
- R3: Writing 1 to control bit 5 raises stallReq for that endpoint on the next cycle. Bit 5 reads back as 1 while the request is set. Writing 0 to bit 5 leaves the request set.
- R4: When setupRcvd is high, the stall request of endpoint setupEp is cleared on the next cycle. This clear wins over a software set of bit 5 on that endpoint in the same cycle.
- R5: Writing 1 to control bit 4 clears that endpoint's stall request, even if bit 5 is written 1 in the same write. Bit 4 reads 1 for exactly one cycle and then returns to 0 without any further write.
- R6: Writing 1 to control bit 3 forces that endpoint's toggle to 0 on the next cycle. This takes priority over a packet acknowledge for the same endpoint in the same cycle. Bit 3 always reads 0.
- R7: When pktAck is high, the toggle of endpoint pktEp inverts on the next cycle. Other endpoints' toggles are unaffected.
- R8: Control bits 2, 1 and 0 are stored per endpoint and read back as written. They drive dfeSel (1 = data-flow engine's endpoint number, 0 = CPU's), dfeRun (1 = run, 0 = pause) and epEnable.
- R9: Bit i of the FIFO reset register drives fifoRst[i]. The line stays high until software writes that bit back to 0.
- R10: During busReset, the next cycle shows all stall requests and toggles at 0 and epEnable equal to only endpoint 0. A control write in the same cycle is dropped. The FIFO reset bits and the stored bits 2:1 keep their values.
- R11: An endpoint index at or above NUM_EP makes a control write change nothing, and a control read return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = control byte of epSel, 1 = FIFO reset register |
| epSel | input | 3 | Endpoint index for control access |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| setupRcvd | input | 1 | SETUP packet received pulse |
| setupEp | input | 3 | Endpoint of the SETUP |
| pktAck | input | 1 | Data packet acknowledged pulse |
| pktEp | input | 3 | Endpoint of the acknowledged packet |
| busReset | input | 1 | USB bus reset detected |
| stallReq | output | NUM_EP | STALL handshake request per endpoint |
| toggle | output | NUM_EP | Current data toggle per endpoint |
| epEnable | output | NUM_EP | Endpoint enable |
| dfeSel | output | NUM_EP | Endpoint number source select |
| dfeRun | output | NUM_EP | Data-flow engine run/pause |
| fifoRst | output | NUM_EP | FIFO reset hold per endpoint |

## Verification
The bench targets the write-only-to-set bits. A design that let a 0 write clear a stall request, or left the stall-clear bit high, shows a stall line or a read-back bit that differs from the expected value. Same-cycle collisions are driven on purpose: SETUP against a stall set, toggle reset against a packet acknowledge, and bus reset against a control write. A wrong priority leaves a stall or toggle set, or an endpoint enabled. Endpoint 0 re-enabling after bus reset, and out-of-range endpoint indices, are checked at the outputs, so a design that writes a phantom slot or aliases index 7 onto a real endpoint is exposed.

// File: rtl/epCtlPkg.sv
package epCtlPkg;
  localparam int EP_IDX_W = 3;
  localparam int MAX_EP   = 7;

  localparam int B_STALL = 5;
  localparam int B_SCLR  = 4;
  localparam int B_TRST  = 3;
  localparam int B_DSEL  = 2;
  localparam int B_DRUN  = 1;
  localparam int B_EN    = 0;

  typedef struct packed {
    logic                ctlWr;
    logic                fifoWr;
    logic [EP_IDX_W-1:0] ep;
    logic                stallSet;
    logic                stallClr;
    logic                togRst;
    logic [2:0]          cfg;
    logic [MAX_EP-1:0]   fifoVal;
    logic                setupHit;
    logic [EP_IDX_W-1:0] setupEp;
    logic                ackHit;
    logic [EP_IDX_W-1:0] ackEp;
    logic                busRst;
    logic                rdValid;
    logic                rdFifo;
  } ctlStrobes_t;
endpackage

// File: rtl/epCtlControl.sv
module epCtlControl
  import epCtlPkg::*;
#(
  parameter int NUM_EP = 7
) (
  input  logic                wrEn,
  input  logic                regSel,
  input  logic [EP_IDX_W-1:0] epSel,
  input  logic [7:0]          wrData,
  input  logic                setupRcvd,
  input  logic [EP_IDX_W-1:0] setupEp,
  input  logic                pktAck,
  input  logic [EP_IDX_W-1:0] pktEp,
  input  logic                busReset,
  output ctlStrobes_t         strb
);
  localparam int CW = EP_IDX_W + 1;
  localparam logic [CW-1:0] EP_LIM = CW'(NUM_EP);

  logic epOk, setupOk, ackOk;

  always_comb begin
    epOk    = ({1'b0, epSel}   < EP_LIM);
    setupOk = ({1'b0, setupEp} < EP_LIM);
    ackOk   = ({1'b0, pktEp}   < EP_LIM);

    strb          = '0;
    strb.ctlWr    = wrEn & ~regSel & epOk & ~busReset;
    strb.fifoWr   = wrEn & regSel;
    strb.ep       = epSel;
    strb.stallSet = wrData[B_STALL];
    strb.stallClr = wrData[B_SCLR];
    strb.togRst   = wrData[B_TRST];
    strb.cfg      = wrData[2:0];
    strb.fifoVal  = wrData[MAX_EP-1:0];
    strb.setupHit = setupRcvd & setupOk;
    strb.setupEp  = setupEp;
    strb.ackHit   = pktAck & ackOk;
    strb.ackEp    = pktEp;
    strb.busRst   = busReset;
    strb.rdValid  = epOk;
    strb.rdFifo   = regSel;
  end
endmodule

// File: rtl/epCtlSlot.sv
module epCtlSlot #(
  parameter bit IS_EP0 = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrHit,
  input  logic       stallSet,
  input  logic       stallClr,
  input  logic       togRst,
  input  logic [2:0] cfg,
  input  logic       setupHit,
  input  logic       ackHit,
  input  logic       busRst,
  input  logic       fifoWr,
  input  logic       fifoVal,
  output logic       stallQ,
  output logic       sclrQ,
  output logic       togQ,
  output logic       enQ,
  output logic       selQ,
  output logic       runQ,
  output logic       fifoQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stallQ <= 1'b0;
      sclrQ  <= 1'b0;
      togQ   <= 1'b0;
      enQ    <= IS_EP0;
      selQ   <= 1'b0;
      runQ   <= 1'b0;
      fifoQ  <= 1'b0;
    end else begin
      // stall request: bus reset, SETUP and clear-write win over set
      if (busRst || setupHit || (wrHit && stallClr))
        stallQ <= 1'b0;
      else if (wrHit && stallSet)
        stallQ <= 1'b1;

      // stall-clear flag lives one cycle
      sclrQ <= wrHit & stallClr & ~busRst;

      // data toggle
      if (busRst || (wrHit && togRst))
        togQ <= 1'b0;
      else if (ackHit)
        togQ <= ~togQ;

      // enable
      if (busRst)
        enQ <= IS_EP0;
      else if (wrHit)
        enQ <= cfg[0];

      if (wrHit) begin
        selQ <= cfg[2];
        runQ <= cfg[1];
      end

      if (fifoWr)
        fifoQ <= fifoVal;
    end
  end
endmodule

// File: rtl/epCtlDatapath.sv
module epCtlDatapath
  import epCtlPkg::*;
#(
  parameter int NUM_EP = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  output logic [7:0]        rdData,
  output logic [NUM_EP-1:0] stallReq,
  output logic [NUM_EP-1:0] toggle,
  output logic [NUM_EP-1:0] epEnable,
  output logic [NUM_EP-1:0] dfeSel,
  output logic [NUM_EP-1:0] dfeRun,
  output logic [NUM_EP-1:0] fifoRst
);
  logic [NUM_EP-1:0] sclrVec;

  for (genvar i = 0; i < NUM_EP; i++) begin : gSlot
    localparam logic [EP_IDX_W-1:0] IDX = EP_IDX_W'(i);
    logic wrHit, setupHit, ackHit;
    assign wrHit    = strb.ctlWr    && (strb.ep      == IDX);
    assign setupHit = strb.setupHit && (strb.setupEp == IDX);
    assign ackHit   = strb.ackHit   && (strb.ackEp   == IDX);

    epCtlSlot #(.IS_EP0(i == 0)) uSlot (
      .clk      (clk),
      .rstN     (rstN),
      .wrHit    (wrHit),
      .stallSet (strb.stallSet),
      .stallClr (strb.stallClr),
      .togRst   (strb.togRst),
      .cfg      (strb.cfg),
      .setupHit (setupHit),
      .ackHit   (ackHit),
      .busRst   (strb.busRst),
      .fifoWr   (strb.fifoWr),
      .fifoVal  (strb.fifoVal[i]),
      .stallQ   (stallReq[i]),
      .sclrQ    (sclrVec[i]),
      .togQ     (toggle[i]),
      .enQ      (epEnable[i]),
      .selQ     (dfeSel[i]),
      .runQ     (dfeRun[i]),
      .fifoQ    (fifoRst[i])
    );
  end

  always_comb begin
    rdData = '0;
    if (strb.rdFifo) begin
      rdData[NUM_EP-1:0] = fifoRst;
    end else if (strb.rdValid) begin
      rdData[B_STALL] = stallReq[strb.ep];
      rdData[B_SCLR]  = sclrVec[strb.ep];
      rdData[B_DSEL]  = dfeSel[strb.ep];
      rdData[B_DRUN]  = dfeRun[strb.ep];
      rdData[B_EN]    = epEnable[strb.ep];
    end
  end
endmodule

// File: rtl/epCtlBank.sv
module epCtlBank
  import epCtlPkg::*;
#(
  parameter int NUM_EP = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                regSel,
  input  logic [EP_IDX_W-1:0] epSel,
  input  logic [7:0]          wrData,
  output logic [7:0]          rdData,
  input  logic                setupRcvd,
  input  logic [EP_IDX_W-1:0] setupEp,
  input  logic                pktAck,
  input  logic [EP_IDX_W-1:0] pktEp,
  input  logic                busReset,
  output logic [NUM_EP-1:0]   stallReq,
  output logic [NUM_EP-1:0]   toggle,
  output logic [NUM_EP-1:0]   epEnable,
  output logic [NUM_EP-1:0]   dfeSel,
  output logic [NUM_EP-1:0]   dfeRun,
  output logic [NUM_EP-1:0]   fifoRst
);
  ctlStrobes_t strb;

  epCtlControl #(.NUM_EP(NUM_EP)) uCtl (
    .wrEn      (wrEn),
    .regSel    (regSel),
    .epSel     (epSel),
    .wrData    (wrData),
    .setupRcvd (setupRcvd),
    .setupEp   (setupEp),
    .pktAck    (pktAck),
    .pktEp     (pktEp),
    .busReset  (busReset),
    .strb      (strb)
  );

  epCtlDatapath #(.NUM_EP(NUM_EP)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdData   (rdData),
    .stallReq (stallReq),
    .toggle   (toggle),
    .epEnable (epEnable),
    .dfeSel   (dfeSel),
    .dfeRun   (dfeRun),
    .fifoRst  (fifoRst)
  );
endmodule

// File: rtl/epCtlChecker.sv
module epCtlChecker
  import epCtlPkg::*;
#(
  parameter int NUM_EP = 7
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                regSel,
  input logic [EP_IDX_W-1:0] epSel,
  input logic [7:0]          wrData,
  input logic [7:0]          rdData,
  input logic                setupRcvd,
  input logic [EP_IDX_W-1:0] setupEp,
  input logic                busReset,
  input logic [NUM_EP-1:0]   stallReq,
  input logic [NUM_EP-1:0]   toggle,
  input logic [NUM_EP-1:0]   epEnable
);
  localparam int CW = EP_IDX_W + 1;
  logic epOk, setupOk, ctlW;
  logic [NUM_EP-1:0] wrMask, setupMask;

  always_comb begin
    epOk      = ({1'b0, epSel}   < CW'(NUM_EP));
    setupOk   = ({1'b0, setupEp} < CW'(NUM_EP));
    wrMask    = epOk    ? (NUM_EP'(1) << epSel)   : '0;
    setupMask = setupOk ? (NUM_EP'(1) << setupEp) : '0;
    ctlW      = wrEn & ~regSel & epOk & ~busReset;
  end

  p_ctl_high_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> rdData[7:6] == 2'b00);

  p_fifo_bit7_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> !rdData[7]);

  p_stall_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlW && !wrData[B_SCLR] && !setupRcvd && ((stallReq & wrMask) != 0))
      |=> ((stallReq & $past(wrMask)) != 0));

  p_setup_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (setupRcvd && setupOk) |=> ((stallReq & $past(setupMask)) == 0));

  p_stall_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlW && wrData[B_SCLR]) |=> ((stallReq & $past(wrMask)) == 0));

  p_toggle_reset_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlW && wrData[B_TRST]) |=> ((toggle & $past(wrMask)) == 0));

  p_bus_reset_r10: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (epEnable == NUM_EP'(1) && stallReq == '0 && toggle == '0));

  p_bad_ep_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!regSel && !epOk) |-> rdData == 8'h00);
endmodule

bind epCtlBank epCtlChecker #(.NUM_EP(NUM_EP)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .regSel    (regSel),
  .epSel     (epSel),
  .wrData    (wrData),
  .rdData    (rdData),
  .setupRcvd (setupRcvd),
  .setupEp   (setupEp),
  .busReset  (busReset),
  .stallReq  (stallReq),
  .toggle    (toggle),
  .epEnable  (epEnable)
);

// File: tb/sim_epCtlBank.sv
`timescale 1ns/100ps
module sim_epCtlBank;
  localparam int NUM_EP = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, regSel = 1'b0, setupRcvd = 1'b0, pktAck = 1'b0, busReset = 1'b0;
  logic [2:0] epSel = '0, setupEp = '0, pktEp = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [NUM_EP-1:0] stallReq, toggle, epEnable, dfeSel, dfeRun, fifoRst;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  epCtlBank #(.NUM_EP(NUM_EP)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .epSel(epSel),
    .wrData(wrData), .rdData(rdData), .setupRcvd(setupRcvd), .setupEp(setupEp),
    .pktAck(pktAck), .pktEp(pktEp), .busReset(busReset), .stallReq(stallReq),
    .toggle(toggle), .epEnable(epEnable), .dfeSel(dfeSel), .dfeRun(dfeRun),
    .fifoRst(fifoRst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [2:0] ep, input logic [7:0] d);
    wrEn = 1'b1; regSel = sel; epSel = ep; wrData = d;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic sel, input logic [2:0] ep, input logic [7:0] exp, input string tag);
    regSel = sel; epSel = ep;
    #1;
    chk(tag, {24'h0, rdData}, {24'h0, exp});
  endtask

  task automatic testReset();
    for (int e = 0; e < NUM_EP; e++)
      rd(1'b0, 3'(e), (e == 0) ? 8'h01 : 8'h00, "R1 ctl reset value");
    rd(1'b1, 3'd0, 8'h00, "R1 fifo reg reset value");
    chk("R1 epEnable", 32'(epEnable), 32'h01);
    chk("R1 toggle/stall/fifoRst", 32'(toggle | stallReq | fifoRst), 32'h0);
  endtask

  task automatic testHighBits();
    wr(1'b0, 3'd1, 8'hC1);
    rd(1'b0, 3'd1, 8'h01, "R2 ctl bits 7:6 dropped");
    wr(1'b1, 3'd0, 8'h80);
    rd(1'b1, 3'd0, 8'h00, "R2 fifo bit 7 reads 0");
    chk("R2 fifoRst unchanged", 32'(fifoRst), 32'h0);
  endtask

  task automatic testStall();
    wr(1'b0, 3'd2, 8'h20);
    chk("R3 stall set", 32'(stallReq), 32'h04);
    rd(1'b0, 3'd2, 8'h20, "R3 stall readback");
    wr(1'b0, 3'd2, 8'h00);
    chk("R3 write 0 keeps stall", 32'(stallReq), 32'h04);
  endtask

  task automatic testSetup();
    setupRcvd = 1'b1; setupEp = 3'd2;
    tick();
    setupRcvd = 1'b0;
    chk("R4 setup clears stall", 32'(stallReq), 32'h0);
    wrEn = 1'b1; regSel = 1'b0; epSel = 3'd3; wrData = 8'h20;
    setupRcvd = 1'b1; setupEp = 3'd3;
    tick();
    wrEn = 1'b0; setupRcvd = 1'b0;
    chk("R4 setup beats same-cycle set", 32'(stallReq), 32'h0);
  endtask

  task automatic testStallClr();
    wr(1'b0, 3'd4, 8'h20);
    chk("R5 precondition stall", 32'(stallReq), 32'h10);
    wr(1'b0, 3'd4, 8'h10);
    chk("R5 clear write drops stall", 32'(stallReq), 32'h0);
    rd(1'b0, 3'd4, 8'h10, "R5 clear bit reads 1 one cycle");
    tick();
    rd(1'b0, 3'd4, 8'h00, "R5 clear bit self-clears");
    wr(1'b0, 3'd4, 8'h30);
    chk("R5 clear wins over set", 32'(stallReq), 32'h0);
  endtask

  task automatic testToggle();
    pktAck = 1'b1; pktEp = 3'd1;
    tick();
    chk("R7 first ack flips", 32'(toggle), 32'h02);
    tick();
    chk("R7 second ack flips back", 32'(toggle), 32'h00);
    pktEp = 3'd5;
    tick();
    pktAck = 1'b0;
    chk("R7 other endpoint only", 32'(toggle), 32'h20);
    pktAck = 1'b1; pktEp = 3'd1;
    tick();
    pktAck = 1'b0;
    chk("R7 ep1 toggled", 32'(toggle), 32'h22);
    wr(1'b0, 3'd1, 8'h08);
    chk("R6 toggle reset", 32'(toggle), 32'h20);
    rd(1'b0, 3'd1, 8'h00, "R6 bit3 reads 0");
    pktAck = 1'b1; pktEp = 3'd1;
    tick();
    chk("R7 ack again", 32'(toggle), 32'h22);
    wrEn = 1'b1; regSel = 1'b0; epSel = 3'd1; wrData = 8'h08;
    tick();
    wrEn = 1'b0; pktAck = 1'b0;
    chk("R6 reset beats same-cycle ack", 32'(toggle), 32'h20);
  endtask

  task automatic testCfg();
    wr(1'b0, 3'd5, 8'h07);
    rd(1'b0, 3'd5, 8'h07, "R8 cfg readback 07");
    chk("R8 outputs set", {29'h0, dfeSel[5], dfeRun[5], epEnable[5]}, 32'h7);
    wr(1'b0, 3'd5, 8'h02);
    rd(1'b0, 3'd5, 8'h02, "R8 cfg readback 02");
    chk("R8 outputs run only", {29'h0, dfeSel[5], dfeRun[5], epEnable[5]}, 32'h2);
  endtask

  task automatic testFifo();
    wr(1'b1, 3'd0, 8'h5A);
    chk("R9 fifoRst set", 32'(fifoRst), 32'h5A);
    rd(1'b1, 3'd0, 8'h5A, "R9 fifo readback");
    repeat (3) tick();
    chk("R9 fifoRst held", 32'(fifoRst), 32'h5A);
    wr(1'b1, 3'd0, 8'h00);
    chk("R9 fifoRst released", 32'(fifoRst), 32'h0);
  endtask

  task automatic testBusReset();
    wr(1'b0, 3'd3, 8'h25);
    pktAck = 1'b1; pktEp = 3'd3;
    tick();
    pktAck = 1'b0;
    wr(1'b1, 3'd0, 8'h08);
    chk("R10 precondition", 32'({stallReq[3], toggle[3], epEnable[3]}), 32'h7);
    busReset = 1'b1;
    wrEn = 1'b1; regSel = 1'b0; epSel = 3'd6; wrData = 8'h21;
    tick();
    busReset = 1'b0; wrEn = 1'b0;
    chk("R10 enables only ep0", 32'(epEnable), 32'h01);
    chk("R10 stall cleared", 32'(stallReq), 32'h0);
    chk("R10 toggles cleared", 32'(toggle), 32'h0);
    chk("R10 fifoRst kept", 32'(fifoRst), 32'h08);
    rd(1'b0, 3'd3, 8'h04, "R10 ep3 sel bit kept");
    rd(1'b0, 3'd6, 8'h00, "R10 same-cycle write dropped");
  endtask

  task automatic testBadEp();
    logic [NUM_EP-1:0] s0, s1, s2, s3, s4;
    s0 = stallReq; s1 = epEnable; s2 = dfeSel; s3 = dfeRun; s4 = toggle;
    wr(1'b0, 3'd7, 8'h2F);
    chk("R11 stall unchanged", 32'(stallReq), 32'(s0));
    chk("R11 enable unchanged", 32'(epEnable), 32'(s1));
    chk("R11 sel/run/toggle unchanged", 32'({dfeSel, dfeRun, toggle}), 32'({s2, s3, s4}));
    rd(1'b0, 3'd7, 8'h00, "R11 read returns 0");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tick();
    testReset();
    testHighBits();
    testStall();
    testSetup();
    testStallClr();
    testToggle();
    testCfg();
    testFifo();
    testBusReset();
    testBadEp();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule